// File: doc/BRIEF.md
# Machine Check Bank Logger

This block holds the machine-check reporting state of one processor core. It contains a capability word, a global control word, a global status word and a set of error banks. Each bank has four 64-bit words: control, status, address and auxiliary information. Software reaches every word through a flat indexed register port.

Error events arrive on an injection port. An event carries a bank index, a bank status word, a global status word, an address, an auxiliary word and a force flag. In a single cycle the block checks the event against the capability word and the current state. It then does one of five things: it rejects the event with a code, drops it, records it, marks an overflow in the existing entry, or asks for a system reset. A reset is requested when an uncorrected error arrives while an earlier one is still being handled, or while machine-check reporting is disabled.

A recorded uncorrected error raises a one-cycle interrupt pulse. Corrected errors are logged without an interrupt.

Top module: `mcb_logger`

## Requirements
- R1: When the capability word is zero, every injection is rejected with code 1 and no state changes.
- R2: The usable bank count is the smaller of capability bits [7:0] and the physical bank count. An injection whose bank index is at or above the usable count is rejected with code 2.
- R3: An injection whose status bit 63 (valid) is clear is rejected with code 3. Checks R1, R2 and R3 take priority in that order, ahead of every other rule.
- R4: While global status bit 2 (in progress) is set, an event whose status bit 55 (action required) is clear is discarded with code 4. The force flag overrides this rule.
- R5: An uncorrected event (status bit 61) is discarded with code 4 in two cases: the bank control word is not all ones, or capability bit 8 is set and the global control word is not all ones. This check comes before the rule in R6.
- R6: An uncorrected event that passes R5 while global status bit 2 is set, or while `mce_en_i` is low, produces a one-cycle `rst_req_o` pulse. In that case nothing is recorded.
- R7: Any other uncorrected event is recorded as follows. The bank status takes the injected value, with bit 62 (overflow) also set if the old status had bit 63 set. The address and auxiliary words are written, the global status takes the injected global value, and `irq_o` pulses.
- R8: A corrected event overwrites status, address and auxiliary words when the old status is not valid, or is valid but not uncorrected. It sets overflow if the old status was valid. Otherwise the event only sets bit 62 of the old status and keeps every other field.
- R9: Register index 0 is capability, 1 is global status and 2 is global control; index 3 reads zero. Bank b occupies indexes 4+4b to 7+4b in the order control, status, address, auxiliary. While `reg_we_i` is high, `inj_ready_o` is low.
- R10: One cycle after an accepted injection, `done_o` pulses and `rej_o` shows the code (0 when accepted). Reset clears every word except capability, which returns to `CAP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mce_en_i | input | 1 | Machine-check reporting enable |
| inj_valid_i | input | 1 | Injection request |
| inj_ready_o | output | 1 | Injection can be accepted |
| inj_bank_i | input | 8 | Target bank index |
| inj_status_i | input | 64 | Bank status value to log |
| inj_gstat_i | input | 64 | Global status value to load |
| inj_addr_i | input | 64 | Error address |
| inj_misc_i | input | 64 | Auxiliary error information |
| inj_force_i | input | 1 | Bypass the in-progress discard rule |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | IDX_W | Register index |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| done_o | output | 1 | Injection completed pulse |
| rej_o | output | 3 | Outcome code: 0 none, 1 unsupported, 2 bad bank, 3 bad status, 4 discarded |
| irq_o | output | 1 | Machine-check interrupt pulse |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with four physical banks and a capability reset value of 0x104: a count of four, with the global-control-present bit set. At run time it rewrites the capability word to zero, then to a count of two with that bit clear. This exposes three cases: the unsupported path, a usable count below the physical bank count, and uncorrected recording with the global control word ignored. The fourth bank is left with its control word at zero. This shows that the control discard is checked before the reset-request path.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   localparam int DW        = 64;
   localparam int ST_VAL    = 63;
   localparam int ST_OVER   = 62;
   localparam int ST_UC     = 61;
   localparam int ST_AR     = 55;
   localparam int GS_BUSY   = 2;
   localparam int CAP_CTLP  = 8;
   localparam int CAP_CNT_W = 8;

   typedef enum logic [2:0] {
      REJ_NONE    = 3'd0,
      REJ_UNSUP   = 3'd1,
      REJ_BANK    = 3'd2,
      REJ_STATUS  = 3'd3,
      REJ_DISCARD = 3'd4
   } rej_e;

   typedef struct packed {
      logic [DW-1:0] ctl;
      logic [DW-1:0] status;
      logic [DW-1:0] addr;
      logic [DW-1:0] misc;
   } bank_t;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
   import mcb_pkg::*;
#(
   parameter int NBANKS = 4
) (
   input  logic [CAP_CNT_W-1:0] bank_i,
   input  logic [DW-1:0]        status_i,
   input  logic                 force_i,
   input  logic                 mce_en_i,
   input  logic [DW-1:0]        cap_i,
   input  logic [DW-1:0]        gstat_i,
   input  logic [DW-1:0]        gctl_i,
   input  logic [DW-1:0]        old_ctl_i,
   input  logic [DW-1:0]        old_status_i,
   output rej_e                 code_o,
   output logic                 rec_uc_o,
   output logic                 overwrite_o,
   output logic                 over_only_o,
   output logic                 reset_o,
   output logic [DW-1:0]        new_status_o
);
   logic in_range;
   logic ctl_block;

   always_comb begin
      in_range  = (32'(bank_i) < 32'(cap_i[CAP_CNT_W-1:0])) &&
                  (32'(bank_i) < 32'(NBANKS));
      ctl_block = (cap_i[CAP_CTLP] && (gctl_i != '1)) || (old_ctl_i != '1);
   end

   always_comb begin
      code_o       = REJ_NONE;
      rec_uc_o     = 1'b0;
      overwrite_o  = 1'b0;
      over_only_o  = 1'b0;
      reset_o      = 1'b0;
      new_status_o = status_i;
      if (cap_i == '0) begin
         code_o = REJ_UNSUP;
      end else if (!in_range) begin
         code_o = REJ_BANK;
      end else if (!status_i[ST_VAL]) begin
         code_o = REJ_STATUS;
      end else if (!force_i && !status_i[ST_AR] && gstat_i[GS_BUSY]) begin
         code_o = REJ_DISCARD;
      end else if (status_i[ST_UC]) begin
         if (ctl_block) begin
            code_o = REJ_DISCARD;
         end else if (gstat_i[GS_BUSY] || !mce_en_i) begin
            reset_o = 1'b1;
         end else begin
            rec_uc_o = 1'b1;
            if (old_status_i[ST_VAL]) new_status_o[ST_OVER] = 1'b1;
         end
      end else if (!old_status_i[ST_VAL] || !old_status_i[ST_UC]) begin
         overwrite_o = 1'b1;
         if (old_status_i[ST_VAL]) new_status_o[ST_OVER] = 1'b1;
      end else begin
         over_only_o = 1'b1;
      end
   end
endmodule

// File: rtl/mcb_global.sv
module mcb_global
   import mcb_pkg::*;
#(
   parameter logic [63:0] CAP_INIT = 64'h104
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_en_i,
   input  logic [1:0]    wr_sel_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          gstat_load_i,
   input  logic [DW-1:0] gstat_in_i,
   output logic [DW-1:0] cap_o,
   output logic [DW-1:0] gstat_o,
   output logic [DW-1:0] gctl_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cap_o   <= CAP_INIT;
         gstat_o <= '0;
         gctl_o  <= '0;
      end else if (wr_en_i) begin
         case (wr_sel_i)
            2'd0:    cap_o   <= wr_data_i;
            2'd1:    gstat_o <= wr_data_i;
            2'd2:    gctl_o  <= wr_data_i;
            default: ;
         endcase
      end else if (gstat_load_i) begin
         gstat_o <= gstat_in_i;
      end
   end

   AST_GSTAT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gstat_load_i && !wr_en_i) |=> (gstat_o == $past(gstat_in_i))); // R7
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
   import mcb_pkg::*;
(
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_en_i,
   input  logic [1:0]    wr_sel_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          load_full_i,
   input  logic          set_over_i,
   input  logic [DW-1:0] status_in_i,
   input  logic [DW-1:0] addr_in_i,
   input  logic [DW-1:0] misc_in_i,
   output bank_t         q_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q_o <= '0;
      end else if (wr_en_i) begin
         case (wr_sel_i)
            2'd0: q_o.ctl    <= wr_data_i;
            2'd1: q_o.status <= wr_data_i;
            2'd2: q_o.addr   <= wr_data_i;
            2'd3: q_o.misc   <= wr_data_i;
         endcase
      end else if (load_full_i) begin
         q_o.status <= status_in_i;
         q_o.addr   <= addr_in_i;
         q_o.misc   <= misc_in_i;
      end else if (set_over_i) begin
         q_o.status[ST_OVER] <= 1'b1;
      end
   end

   AST_OVER_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_over_i && !wr_en_i && !load_full_i) |=> (q_o.status[ST_OVER] && q_o.status[ST_VAL])); // R8
   AST_FULL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_full_i && !wr_en_i) |=> (q_o.addr == $past(addr_in_i) && q_o.misc == $past(misc_in_i))); // R7
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
   import mcb_pkg::*;
#(
   parameter int          NBANKS   = 4,
   parameter logic [63:0] CAP_INIT = 64'h104,
   localparam int         IDX_W    = $clog2(4 + 4 * NBANKS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mce_en_i,
   input  logic              inj_valid_i,
   output logic              inj_ready_o,
   input  logic [7:0]        inj_bank_i,
   input  logic [63:0]       inj_status_i,
   input  logic [63:0]       inj_gstat_i,
   input  logic [63:0]       inj_addr_i,
   input  logic [63:0]       inj_misc_i,
   input  logic              inj_force_i,
   input  logic              reg_we_i,
   input  logic [IDX_W-1:0]  reg_idx_i,
   input  logic [63:0]       reg_wdata_i,
   output logic [63:0]       reg_rdata_o,
   output logic              done_o,
   output logic [2:0]        rej_o,
   output logic              irq_o,
   output logic              rst_req_o
);
   localparam int HI_W = IDX_W - 2;

   generate
      if (NBANKS < 1 || NBANKS > 255) begin : g_bad_nbanks
         $error("mcb_logger: NBANKS must be 1..255");
      end
   endgenerate

   logic [DW-1:0] cap, gstat, gctl;
   bank_t         banks [NBANKS];
   logic [HI_W-1:0] idx_hi;
   logic          fire;
   logic [DW-1:0] sel_ctl, sel_status;
   rej_e          code;
   logic          rec_uc, overwrite, over_only, want_reset;
   logic [DW-1:0] new_status;

   assign idx_hi      = reg_idx_i[IDX_W-1:2];
   assign inj_ready_o = !reg_we_i;
   assign fire        = inj_valid_i && inj_ready_o;

   always_comb begin
      sel_ctl    = '0;
      sel_status = '0;
      for (int b = 0; b < NBANKS; b++) begin
         if (32'(inj_bank_i) == 32'(b)) begin
            sel_ctl    = banks[b].ctl;
            sel_status = banks[b].status;
         end
      end
   end

   mcb_decide #(.NBANKS(NBANKS)) u_decide (
      .bank_i       (inj_bank_i),
      .status_i     (inj_status_i),
      .force_i      (inj_force_i),
      .mce_en_i     (mce_en_i),
      .cap_i        (cap),
      .gstat_i      (gstat),
      .gctl_i       (gctl),
      .old_ctl_i    (sel_ctl),
      .old_status_i (sel_status),
      .code_o       (code),
      .rec_uc_o     (rec_uc),
      .overwrite_o  (overwrite),
      .over_only_o  (over_only),
      .reset_o      (want_reset),
      .new_status_o (new_status)
   );

   mcb_global #(.CAP_INIT(CAP_INIT)) u_global (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (reg_we_i && (idx_hi == '0)),
      .wr_sel_i     (reg_idx_i[1:0]),
      .wr_data_i    (reg_wdata_i),
      .gstat_load_i (fire && rec_uc),
      .gstat_in_i   (inj_gstat_i),
      .cap_o        (cap),
      .gstat_o      (gstat),
      .gctl_o       (gctl)
   );

   for (genvar g = 0; g < NBANKS; g++) begin : g_bank
      logic hit;
      assign hit = (32'(inj_bank_i) == 32'(g));
      mcb_bank u_bank (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .wr_en_i     (reg_we_i && (idx_hi == HI_W'(g + 1))),
         .wr_sel_i    (reg_idx_i[1:0]),
         .wr_data_i   (reg_wdata_i),
         .load_full_i (fire && hit && (rec_uc || overwrite)),
         .set_over_i  (fire && hit && over_only),
         .status_in_i (new_status),
         .addr_in_i   (inj_addr_i),
         .misc_in_i   (inj_misc_i),
         .q_o         (banks[g])
      );
   end

   always_comb begin
      reg_rdata_o = '0;
      if (idx_hi == '0) begin
         case (reg_idx_i[1:0])
            2'd0:    reg_rdata_o = cap;
            2'd1:    reg_rdata_o = gstat;
            2'd2:    reg_rdata_o = gctl;
            default: reg_rdata_o = '0;
         endcase
      end else begin
         for (int b = 0; b < NBANKS; b++) begin
            if (idx_hi == HI_W'(b + 1)) begin
               case (reg_idx_i[1:0])
                  2'd0: reg_rdata_o = banks[b].ctl;
                  2'd1: reg_rdata_o = banks[b].status;
                  2'd2: reg_rdata_o = banks[b].addr;
                  2'd3: reg_rdata_o = banks[b].misc;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         done_o    <= 1'b0;
         rej_o     <= REJ_NONE;
         irq_o     <= 1'b0;
         rst_req_o <= 1'b0;
      end else begin
         done_o    <= fire;
         rej_o     <= fire ? code : REJ_NONE;
         irq_o     <= fire && rec_uc;
         rst_req_o <= fire && want_reset;
      end
   end

   AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(irq_o && rst_req_o)); // R6
   AST_REJ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rej_o != REJ_NONE) |-> (!irq_o && !rst_req_o && done_o)); // R10
   AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && code != REJ_NONE) |=> $stable(gstat)); // R4
   AST_NO_FIRE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_we_i |-> !done_o || $past(inj_valid_i && !reg_we_i)); // R9
endmodule

// File: tb/mcb_logger_bench.sv
`timescale 1ns/1ps
module mcb_logger_bench;
   localparam int IDX_W = 5;
   localparam logic [63:0] V = 64'h8000_0000_0000_0000;
   localparam logic [63:0] O = 64'h4000_0000_0000_0000;
   localparam logic [63:0] U = 64'h2000_0000_0000_0000;
   localparam logic [63:0] A = 64'h0080_0000_0000_0000;

   typedef struct packed {
      logic [7:0]  req;
      logic [7:0]  bank;
      logic [63:0] status;
      logic [63:0] gstat;
      logic        force_f;
      logic [2:0]  code;
      logic        irq;
      logic        rst;
      logic [7:0]  chk;
      logic [63:0] est;
      logic [63:0] egs;
   } vec_t;

   // R8 first write, R8 overwrite with overflow, R7 uncorrected record,
   // R4 busy discard, R4 force bypass, R8 overflow only, R6 reset request,
   // R5 bank control discard ahead of R6, R2 bad bank, R3 bad status
   localparam vec_t TBL [10] = '{
      '{8'd8, 8'd0, V | 64'h11,     64'd0, 1'b0, 3'd0, 1'b0, 1'b0, 8'd0, V | 64'h11,         64'd0},
      '{8'd8, 8'd0, V | 64'h22,     64'd0, 1'b0, 3'd0, 1'b0, 1'b0, 8'd0, V | O | 64'h22,     64'd0},
      '{8'd7, 8'd1, V | U | 64'h33, 64'd5, 1'b0, 3'd0, 1'b1, 1'b0, 8'd1, V | U | 64'h33,     64'd5},
      '{8'd4, 8'd2, V | 64'h44,     64'd0, 1'b0, 3'd4, 1'b0, 1'b0, 8'd2, 64'd0,              64'd5},
      '{8'd4, 8'd2, V | 64'h44,     64'd0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd2, V | 64'h44,         64'd5},
      '{8'd8, 8'd1, V | 64'h55,     64'd0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd1, V | O | U | 64'h33, 64'd5},
      '{8'd6, 8'd0, V|U|A|64'h66,   64'd0, 1'b0, 3'd0, 1'b0, 1'b1, 8'd0, V | O | 64'h22,     64'd5},
      '{8'd5, 8'd3, V|U|A|64'h77,   64'd0, 1'b0, 3'd4, 1'b0, 1'b0, 8'd3, 64'd0,              64'd5},
      '{8'd2, 8'd4, V | 64'h01,     64'd0, 1'b0, 3'd2, 1'b0, 1'b0, 8'd0, V | O | 64'h22,     64'd5},
      '{8'd3, 8'd0, 64'h01,         64'd0, 1'b1, 3'd3, 1'b0, 1'b0, 8'd0, V | O | 64'h22,     64'd5}
   };

   logic clk = 1'b0, rst_n = 1'b0, mce_en = 1'b1;
   logic inj_valid = 1'b0, inj_ready, inj_force = 1'b0;
   logic [7:0] inj_bank = '0;
   logic [63:0] inj_status = '0, inj_gstat = '0, inj_addr = '0, inj_misc = '0;
   logic reg_we = 1'b0;
   logic [IDX_W-1:0] reg_idx = '0;
   logic [63:0] reg_wdata = '0, reg_rdata;
   logic done, irq, rst_req;
   logic [2:0] rej;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mcb_logger #(.NBANKS(4), .CAP_INIT(64'h104)) u_mcb_logger (
      .clk_i(clk), .rst_ni(rst_n), .mce_en_i(mce_en),
      .inj_valid_i(inj_valid), .inj_ready_o(inj_ready), .inj_bank_i(inj_bank),
      .inj_status_i(inj_status), .inj_gstat_i(inj_gstat), .inj_addr_i(inj_addr),
      .inj_misc_i(inj_misc), .inj_force_i(inj_force),
      .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .done_o(done), .rej_o(rej), .irq_o(irq),
      .rst_req_o(rst_req)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input int idx, output logic [63:0] val);
      reg_idx = IDX_W'(idx);
      #0.5;
      val = reg_rdata;
   endtask

   task automatic wr(input int idx, input logic [63:0] data);
      reg_we = 1'b1; reg_idx = IDX_W'(idx); reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic inj(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                      input logic [63:0] ad, input logic [63:0] ms, input logic f);
      inj_valid = 1'b1; inj_bank = b; inj_status = st; inj_gstat = gs;
      inj_addr = ad; inj_misc = ms; inj_force = f;
      @(negedge clk);
      inj_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [63:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      rd(0, r); check("R10 cap after reset", r, 64'h104);
      rd(1, r); check("R10 gstat after reset", r, 64'd0);
      rd(5, r); check("R10 bank0 status after reset", r, 64'd0);
      check("R10 pulses idle", {61'd0, done, irq, rst_req}, 64'd0);
      check("R9 ready idle", {63'd0, inj_ready}, 64'd1);
      // R9 register write blocks injection, map layout
      reg_we = 1'b1; reg_idx = 5'd2; reg_wdata = '1;
      #0.5;
      check("R9 ready low during write", {63'd0, inj_ready}, 64'd0);
      @(negedge clk);
      reg_we = 1'b0;
      wr(4, '1); wr(8, '1); wr(12, '1);
      rd(3, r); check("R9 index 3 reads zero", r, 64'd0);
      rd(8, r); check("R9 bank1 control word", r, '1);

      for (int i = 0; i < 10; i++) begin
         vec_t v;
         v = TBL[i];
         inj(v.bank, v.status, v.gstat, 64'h1000 + 64'(i), 64'h2000 + 64'(i), v.force_f);
         check($sformatf("R%0d vec%0d done", v.req, i), {63'd0, done}, 64'd1);
         check($sformatf("R%0d vec%0d code", v.req, i), {61'd0, rej}, {61'd0, v.code});
         check($sformatf("R%0d vec%0d irq", v.req, i), {63'd0, irq}, {63'd0, v.irq});
         check($sformatf("R%0d vec%0d rst", v.req, i), {63'd0, rst_req}, {63'd0, v.rst});
         rd(5 + 4 * int'(v.chk), r);
         check($sformatf("R%0d vec%0d bank status", v.req, i), r, v.est);
         rd(1, r);
         check($sformatf("R%0d vec%0d gstat", v.req, i), r, v.egs);
         @(negedge clk);
         check($sformatf("R10 vec%0d pulses end", i), {61'd0, done, irq, rst_req}, 64'd0);
      end

      rd(10, r); check("R7 bank1 address recorded", r, 64'h1002);
      rd(11, r); check("R8 bank1 misc kept on overflow only", r, 64'h2002);
      rd(6, r);  check("R6 bank0 address untouched by reset path", r, 64'h1001);

      // R1 capability zero
      wr(1, 64'd0); wr(0, 64'd0);
      inj(8'd0, V | 64'h1, 64'd0, 64'h0, 64'h0, 1'b0);
      check("R1 unsupported code", {61'd0, rej}, 64'd1);
      // R2 count from capability below physical banks
      wr(0, 64'h002); wr(2, 64'd0);
      inj(8'd2, V | 64'h1, 64'd0, 64'h0, 64'h0, 1'b0);
      check("R2 bank beyond count", {61'd0, rej}, 64'd2);
      // R5 global control ignored without presence bit, R7 overflow on valid
      inj(8'd1, V | U | 64'h88, 64'd1, 64'h3000, 64'h4000, 1'b0);
      check("R5 no presence bit, recorded", {61'd0, rej}, 64'd0);
      check("R7 irq pulse", {63'd0, irq}, 64'd1);
      rd(9, r); check("R7 overflow on prior valid", r, V | O | U | 64'h88);
      rd(1, r); check("R7 gstat loaded", r, 64'd1);
      // R6 enable low requests reset
      mce_en = 1'b0;
      inj(8'd0, V | U | 64'h99, 64'd0, 64'h0, 64'h0, 1'b0);
      check("R6 reset on disabled", {63'd0, rst_req}, 64'd1);
      rd(5, r); check("R6 nothing recorded", r, V | O | 64'h22);
      mce_en = 1'b1;
      // R5 presence bit with global control not all ones
      wr(0, 64'h104);
      inj(8'd0, V | U | 64'haa, 64'd0, 64'h0, 64'h0, 1'b0);
      check("R5 global control discard", {61'd0, rej}, 64'd4);
      // R10 reset clears all but capability
      wr(0, 64'h003);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(0, r); check("R10 cap restored", r, 64'h104);
      rd(9, r); check("R10 bank1 status cleared", r, 64'd0);
      rd(4, r); check("R10 bank0 control cleared", r, 64'd0);
      rd(1, r); check("R10 gstat cleared", r, 64'd0);
      finish_run();
   end
endmodule